// File: doc/BRIEF.md
# Eight-bit Arithmetic Unit with Operand Latch and Condition Flags

This block is the arithmetic unit of a small 8-bit processor, together with the condition-flag register that conditional branches read. The second operand does not come from any general register. It comes from a private operand latch that is written from the shared processor bus. That latch is wiped at the end of every instruction, so any instruction that never loads it works against an implicit zero. Microcode spends one cycle copying a register or an immediate offset into the latch when a real second operand is needed, for example when a stack-relative access adds an offset to the stack pointer.

The result register captures the selected function of the A operand and the latch on every clock. Flags change only on request. An ALU-sourced update writes zero, negative and carry from the result being captured. A bus-sourced update writes zero and negative from the bus value and keeps carry, so a load or move into a register can set the flags without using the arithmetic path. When neither update is requested, the flags hold, and address arithmetic leaves them alone.

Top module: `alu8_core`

## Requirements
- R1: While rst_n is low and after it rises, alu_res is 0, the operand latch is 0, and flg_z, flg_n and flg_c are all 0.
- R2: On a rising edge with instr_end_n low, the operand latch becomes 0. This clear wins over ld_opnd in the same cycle.
- R3: On a rising edge with ld_opnd high and instr_end_n high, the operand latch takes bus_in. The new value is first used by the computation in the following cycle.
- R4: On every rising edge, alu_res takes f(a_in, latch) using the latch value before that edge. The fn_sel encodings are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR and 5 pass A. Codes 6 and 7 also pass A.
- R5: The carry of a function is the carry-out of bit 7 for add and the borrow (a_in < latch) for subtract. It is 0 for all other functions.
- R6: On a rising edge with upd_alu high, flg_z becomes (result == 0), flg_n becomes result bit 7 and flg_c becomes the function's carry. These values belong to the same result that alu_res captures on that edge.
- R7: On a rising edge with upd_bus high and upd_alu low, flg_z becomes (bus_in == 0) and flg_n becomes bus_in[7], while flg_c is unchanged.
- R8: When upd_alu and upd_bus are both high, the ALU-sourced update is the one applied.
- R9: On a rising edge with upd_alu and upd_bus both low, all three flags keep their values.
- R10: res_drv_en follows res_oe in the same cycle, with no register in between.
- R11: After an instruction-end clear, an add with no latch load returns a_in unchanged, because the operand is the implicit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 8 | Shared processor bus value |
| a_in | input | 8 | A operand |
| fn_sel | input | 3 | Function select |
| ld_opnd | input | 1 | Write bus_in into the operand latch |
| upd_alu | input | 1 | Update Z, N, C from the ALU result |
| upd_bus | input | 1 | Update Z, N from bus_in |
| instr_end_n | input | 1 | End-of-instruction strobe, active low |
| res_oe | input | 1 | Request to place the result on the bus |
| alu_res | output | 8 | Result register contents |
| res_drv_en | output | 1 | Bus-enable for the result |
| flg_z | output | 1 | Zero flag |
| flg_n | output | 1 | Negative flag |
| flg_c | output | 1 | Carry / borrow flag |

## Verification
A stale or uncleared operand latch shows up on alu_res exactly one clock after the next computation uses it. An add that should echo a_in instead returns a shifted value. A carry lost or corrupted in the flag register is visible at flg_c right after the offending edge, and again when a later bus-sourced update fails to leave it alone. Update priority faults show within one cycle, because the two flag sources always disagree in the cases that are driven.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SUB   = 3'd1,
    FN_AND   = 3'd2,
    FN_OR    = 3'd3,
    FN_XOR   = 3'd4,
    FN_PASSA = 3'd5
  } alu_fn_e;

  typedef struct packed {
    logic [7:0] val;
    logic       cy;
  } alu_out_t;

  // Arithmetic of one cycle: result and carry/borrow.
  function automatic alu_out_t alu_eval(input logic [2:0] fn,
                                        input logic [7:0] a,
                                        input logic [7:0] b);
    alu_out_t   o;
    logic [8:0] w;
    o = '0;
    w = '0;
    case (fn)
      FN_ADD: begin
        w = {1'b0, a} + {1'b0, b};
        o.val = w[7:0];
        o.cy  = w[8];
      end
      FN_SUB: begin
        w = {1'b0, a} - {1'b0, b};
        o.val = w[7:0];
        o.cy  = w[8];
      end
      FN_AND: o.val = a & b;
      FN_OR:  o.val = a | b;
      FN_XOR: o.val = a ^ b;
      default: o.val = a;
    endcase
    return o;
  endfunction

  function automatic logic is_zero(input logic [7:0] v);
    return (v == 8'h00);
  endfunction

endpackage

// File: rtl/alu8_opnd_latch.sv
module alu8_opnd_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  input  logic         ld,
  input  logic         clr_n,
  output logic [W-1:0] q,
  output logic         clr_evt,
  output logic         ld_evt
);
  // Clear takes precedence over load.
  assign clr_evt = ~clr_n;
  assign ld_evt  = ld & clr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (clr_evt) q <= '0;
    else if (ld_evt)  q <= d_in;
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] fn,
  input  logic [7:0] a,
  input  logic [7:0] b,
  output logic [7:0] nxt_val,
  output logic       nxt_cy,
  output logic [7:0] res_q
);
  alu_out_t o;

  always_comb o = alu_eval(fn, a, b);
  assign nxt_val = o.val;
  assign nxt_cy  = o.cy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= o.val;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] alu_val,
  input  logic       alu_cy,
  input  logic [7:0] bus_val,
  input  logic       from_alu,
  input  logic       from_bus,
  output logic       z_q,
  output logic       n_q,
  output logic       c_q,
  output logic       sel_alu,
  output logic       sel_bus
);
  // The ALU source has priority over the bus source.
  assign sel_alu = from_alu;
  assign sel_bus = from_bus & ~from_alu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= 1'b0;
      n_q <= 1'b0;
      c_q <= 1'b0;
    end else if (sel_alu) begin
      z_q <= is_zero(alu_val);
      n_q <= alu_val[7];
      c_q <= alu_cy;
    end else if (sel_bus) begin
      z_q <= is_zero(bus_val);
      n_q <= bus_val[7];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_in,
  input  logic [7:0] a_in,
  input  logic [2:0] fn_sel,
  input  logic       ld_opnd,
  input  logic       upd_alu,
  input  logic       upd_bus,
  input  logic       instr_end_n,
  input  logic       res_oe,
  output logic [7:0] alu_res,
  output logic       res_drv_en,
  output logic       flg_z,
  output logic       flg_n,
  output logic       flg_c
);
  logic [7:0] opnd_b;
  logic       opnd_clr_evt;
  logic       opnd_ld_evt;
  logic [7:0] nxt_val;
  logic       nxt_cy;
  logic       flag_sel_alu;
  logic       flag_sel_bus;

  alu8_opnd_latch #(.W(8)) u_opnd (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_in    (bus_in),
    .ld      (ld_opnd),
    .clr_n   (instr_end_n),
    .q       (opnd_b),
    .clr_evt (opnd_clr_evt),
    .ld_evt  (opnd_ld_evt)
  );

  alu8_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .fn      (fn_sel),
    .a       (a_in),
    .b       (opnd_b),
    .nxt_val (nxt_val),
    .nxt_cy  (nxt_cy),
    .res_q   (alu_res)
  );

  alu8_flags u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .alu_val  (nxt_val),
    .alu_cy   (nxt_cy),
    .bus_val  (bus_in),
    .from_alu (upd_alu),
    .from_bus (upd_bus),
    .z_q      (flg_z),
    .n_q      (flg_n),
    .c_q      (flg_c),
    .sel_alu  (flag_sel_alu),
    .sel_bus  (flag_sel_bus)
  );

  assign res_drv_en = res_oe;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_in,
  input logic       ld_opnd,
  input logic       upd_alu,
  input logic       upd_bus,
  input logic       instr_end_n,
  input logic [7:0] opnd_b,
  input logic [7:0] alu_res,
  input logic       flg_z,
  input logic       flg_n,
  input logic       flg_c
);
  a_r2_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_end_n |=> (opnd_b == 8'h00));

  a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_opnd && instr_end_n) |=> (opnd_b == $past(bus_in)));

  // R6 and R8: the flags agree with the captured result after an ALU update.
  a_r6_flags_match_result: assert property (@(posedge clk) disable iff (!rst_n)
    upd_alu |=> (flg_z == (alu_res == 8'h00)) && (flg_n == alu_res[7]));

  a_r7_bus_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_bus && !upd_alu) |=> (flg_z == ($past(bus_in) == 8'h00))
                           && (flg_n == $past(bus_in[7]))
                           && (flg_c == $past(flg_c)));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_alu && !upd_bus) |=> $stable({flg_z, flg_n, flg_c}));
endmodule

bind alu8_core alu8_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_in      (bus_in),
  .ld_opnd     (ld_opnd),
  .upd_alu     (upd_alu),
  .upd_bus     (upd_bus),
  .instr_end_n (instr_end_n),
  .opnd_b      (opnd_b),
  .alu_res     (alu_res),
  .flg_z       (flg_z),
  .flg_n       (flg_n),
  .flg_c       (flg_c)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] a_in = '0;
  logic [2:0] fn_sel = '0;
  logic       ld_opnd = 1'b0;
  logic       upd_alu = 1'b0;
  logic       upd_bus = 1'b0;
  logic       instr_end_n = 1'b1;
  logic       res_oe = 1'b0;
  logic [7:0] alu_res;
  logic       res_drv_en;
  logic       flg_z, flg_n, flg_c;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  logic [7:0] m_b = '0;
  logic       m_z = 0, m_n = 0, m_c = 0;

  always #4 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .a_in(a_in), .fn_sel(fn_sel),
    .ld_opnd(ld_opnd), .upd_alu(upd_alu), .upd_bus(upd_bus),
    .instr_end_n(instr_end_n), .res_oe(res_oe), .alu_res(alu_res),
    .res_drv_en(res_drv_en), .flg_z(flg_z), .flg_n(flg_n), .flg_c(flg_c)
  );

  // Reference arithmetic, written as a 9-bit sum with a two's-complement subtract.
  function automatic logic [8:0] ref_op(input logic [2:0] f, input logic [7:0] a,
                                        input logic [7:0] b);
    logic [8:0] s;
    case (f)
      3'd0: s = {1'b0, a} + {1'b0, b};
      3'd1: begin
        s = {1'b0, a} + {1'b0, ~b} + 9'd1;
        s[8] = ~s[8];
      end
      3'd2: s = {1'b0, a & b};
      3'd3: s = {1'b0, a | b};
      3'd4: s = {1'b0, a ^ b};
      default: s = {1'b0, a};
    endcase
    return s;
  endfunction

  task automatic report(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {res,z,n,c} actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic step(input string tag, input logic [2:0] f, input logic [7:0] a,
                      input logic [7:0] bus, input bit ld, input bit ua, input bit ub,
                      input bit endn, input bit oe);
    logic [8:0] r;
    @(negedge clk);
    fn_sel = f; a_in = a; bus_in = bus; ld_opnd = ld; upd_alu = ua;
    upd_bus = ub; instr_end_n = endn; res_oe = oe;
    r = ref_op(f, a, m_b);
    if (ua) begin
      m_z = (r[7:0] == 0); m_n = r[7]; m_c = r[8];
    end else if (ub) begin
      m_z = (bus == 0); m_n = bus[7];
    end
    if (!endn) m_b = 8'h00;
    else if (ld) m_b = bus;
    exp_q.push_back({r[7:0], m_z, m_n, m_c});
    tag_q.push_back(tag);
    #1;
    report("R10 res_drv_en", {10'd0, res_drv_en}, {10'd0, oe});
  endtask

  // Monitor: compares each result shortly after the edge that produced it.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [10:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      report(t, {alu_res, flg_z, flg_n, flg_c}, e);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    report("R1 during reset", {alu_res, flg_z, flg_n, flg_c}, 11'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    report("R1 after reset", {alu_res, flg_z, flg_n, flg_c}, 11'd0);

    step("R11 implicit zero add",  3'd0, 8'h05, 8'h00, 0, 0, 0, 1, 0);
    step("R3 load, old operand",   3'd0, 8'h05, 8'h03, 1, 0, 0, 1, 1);
    step("R4 add uses loaded",     3'd0, 8'h05, 8'h00, 0, 1, 0, 1, 0);
    step("R5 subtract borrow",     3'd1, 8'h02, 8'h00, 0, 1, 0, 1, 0);
    step("R5 add carry out",       3'd0, 8'hFE, 8'h00, 0, 1, 0, 1, 0);
    step("R6 AND zero flag",       3'd2, 8'h0C, 8'h00, 0, 1, 0, 1, 1);
    step("R4 OR",                  3'd3, 8'h90, 8'h00, 0, 1, 0, 1, 0);
    step("R4 XOR",                 3'd4, 8'h03, 8'h00, 0, 1, 0, 1, 0);
    step("R4 pass A",              3'd5, 8'hA7, 8'h00, 0, 1, 0, 1, 0);
    step("R4 code 7 passes A",     3'd7, 8'h42, 8'h00, 0, 0, 0, 1, 0);
    step("R5 carry set before bus", 3'd1, 8'h00, 8'h00, 0, 1, 0, 1, 0);
    step("R7 bus flags keep C",    3'd0, 8'h00, 8'h80, 0, 0, 1, 1, 0);
    step("R7 bus zero",            3'd0, 8'h00, 8'h00, 0, 0, 1, 1, 0);
    step("R8 ALU beats bus",       3'd0, 8'h10, 8'h00, 0, 1, 1, 1, 0);
    step("R9 flags hold",          3'd5, 8'h00, 8'h00, 0, 0, 0, 1, 0);
    step("R2 clear beats load",    3'd0, 8'h01, 8'h77, 1, 0, 0, 0, 0);
    step("R11 add after clear",    3'd0, 8'h3C, 8'h00, 0, 1, 0, 1, 0);
    step("R3 load FF",             3'd0, 8'h00, 8'hFF, 1, 0, 0, 1, 0);
    step("R5 add wrap carry",      3'd0, 8'h01, 8'h00, 0, 1, 0, 1, 0);
    step("R5 equal subtract",      3'd1, 8'hFF, 8'h00, 0, 1, 0, 1, 0);
    step("R2 end strobe",          3'd5, 8'h00, 8'h00, 0, 0, 0, 0, 0);
    step("R5 sub zero no borrow",  3'd1, 8'h09, 8'h00, 0, 1, 0, 1, 0);
    step("R9 idle",                3'd0, 8'h00, 8'h00, 0, 0, 0, 1, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule